// File: doc/BRIEF.md
# ATA Task File Register Front End

This block is the host-facing register layer of an ATA-style storage device. A host bus reads and writes byte-wide task-file registers (feature, sector count, three address bytes, device select, command) and a 16-bit data port. The block keeps those registers and hands their values to a separate command engine. It passes data-port words to and from a word buffer. It forwards each accepted command byte with a single-cycle strobe.

Some bus addresses are shared between two registers. At the address of the feature register a read returns the error register. At the command address a read returns status. At the alternate address a write lands in the device-control register and a read returns status without side effects. The engine alone updates status and error. The block uses the BSY and DRQ bits of status to refuse task-file writes while the device cannot take them. The block also owns the device interrupt line: the engine sets it, and a primary status read or an accepted command write clears it.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After a synchronous reset, status is 0x50, error is 0x01, `dev_irq` is 0, the six task-file outputs and `tf_devctl` are 0, and no strobe is active.
- R2: Writes at addresses 1 to 6 (1 feature, 2 count, 3 LBA byte 0, 4 LBA byte 1, 5 LBA byte 2, 6 device) store only the low byte of `bus_wdata` when status bit 7 (BSY) and bit 3 (DRQ) are both 0. The stored value is visible on the matching `tf_*` output one cycle later. Addresses 2 to 6 read back the stored byte.
- R3: While BSY or DRQ is 1, writes at addresses 1 to 7 are dropped. No register changes and `cmd_stb` stays low.
- R4: A write at address 7 while writes are permitted raises `cmd_stb` for exactly one cycle, on the next cycle, with `cmd_code` equal to the low byte of the write. It also clears `dev_irq` on that same cycle.
- R5: A write at address 14 stores its low byte in `tf_devctl` whatever the BSY and DRQ bits are. It leaves status unchanged.
- R6: A read at address 1 returns the error register, never the feature value.
- R7: A read at address 7 returns status and clears `dev_irq`. A read at address 14 returns the same status and leaves `dev_irq` unchanged.
- R8: A cycle with `eng_irq` high sets `dev_irq` on the next cycle, even if a clear happens in the same cycle. `dev_irq` then holds its value until it is cleared.
- R9: A write at address 0 gives a one-cycle `buf_wr_stb` on the next cycle, with the full 16-bit word on `buf_wdata`. A read at address 0 returns `buf_rdata` on `bus_rdata` and gives a one-cycle `buf_rd_stb` on the next cycle. The data port is never gated.
- R10: `bus_rdata` is updated only on the cycle after a read and holds its value otherwise. Byte registers read with the upper byte 0. Unmapped addresses read as 0.
- R11: `eng_status_we` and `eng_error_we` load `eng_status` and `eng_error` into the status and error registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Host register address |
| bus_wr | input | 1 | Host write for one cycle |
| bus_rd | input | 1 | Host read for one cycle |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| buf_rd_stb | output | 1 | Pop strobe toward the data buffer |
| buf_wr_stb | output | 1 | Push strobe toward the data buffer |
| buf_wdata | output | 16 | Word pushed to the data buffer |
| buf_rdata | input | 16 | Head word offered by the data buffer |
| cmd_stb | output | 1 | Command issued to the engine |
| cmd_code | output | 8 | Command byte |
| eng_status_we | input | 1 | Engine loads status |
| eng_status | input | 8 | New status value |
| eng_error_we | input | 1 | Engine loads error |
| eng_error | input | 8 | New error value |
| eng_irq | input | 1 | Engine interrupt request |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_lba0 | output | 8 | LBA byte 0 |
| tf_lba1 | output | 8 | LBA byte 1 |
| tf_lba2 | output | 8 | LBA byte 2 |
| tf_device | output | 8 | Device/head register |
| tf_devctl | output | 8 | Device control register |
| dev_irq | output | 1 | Device interrupt line |

## Verification
The assertions check the following on every cycle: gated task-file registers stay put under a refused write, accepted bytes land, a command strobe only follows a permitted write, the interrupt latch gives set priority over clear and otherwise holds, read data holds between reads, and buffer strobes only follow data-port accesses. Only the bench scenarios can show the address aliasing as a whole. That means the error register at the feature address, status at both status addresses with different interrupt side effects, and device control accepted while busy. The same holds for the reset values and the exact cycle on which each strobe and read word appears.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_TF = 6;
  localparam int BSY_BIT = 7;
  localparam int DRQ_BIT = 3;
  localparam logic [7:0] STATUS_RST = 8'h50;
  localparam logic [7:0] ERROR_RST  = 8'h01;

  localparam logic [ADDR_W-1:0] A_DATA = 4'd0;
  localparam logic [ADDR_W-1:0] A_FEAT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALT  = 4'd14;

  localparam int TF_FEAT  = 0;
  localparam int TF_COUNT = 1;
  localparam int TF_LBA0  = 2;
  localparam int TF_LBA1  = 3;
  localparam int TF_LBA2  = 4;
  localparam int TF_DEV   = 5;

  typedef struct packed {
    logic              data_wr;
    logic              data_rd;
    logic [NUM_TF-1:0] tf_wr;
    logic              cmd_wr;
    logic              ctl_wr;
    logic              stat_rd;
  } hit_t;
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output hit_t              hit
);
  always_comb begin
    hit = '0;
    hit.data_wr = bus_wr && (bus_addr == A_DATA);
    hit.data_rd = bus_rd && (bus_addr == A_DATA);
    hit.cmd_wr  = bus_wr && (bus_addr == A_CMD);
    hit.ctl_wr  = bus_wr && (bus_addr == A_ALT);
    hit.stat_rd = bus_rd && (bus_addr == A_CMD);
    for (int i = 0; i < NUM_TF; i++)
      hit.tf_wr[i] = bus_wr && (bus_addr == A_FEAT + ADDR_W'(i));
  end
endmodule

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
  import ata_tf_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  hit_t                         hit,
  input  logic [REG_W-1:0]             wbyte,
  input  logic                         eng_status_we,
  input  logic [REG_W-1:0]             eng_status,
  input  logic                         eng_error_we,
  input  logic [REG_W-1:0]             eng_error,
  output logic [NUM_TF-1:0][REG_W-1:0] tf_q,
  output logic [REG_W-1:0]             devctl_q,
  output logic [REG_W-1:0]             status_q,
  output logic [REG_W-1:0]             error_q,
  output logic                         cmd_stb,
  output logic [REG_W-1:0]             cmd_code,
  output logic                         wr_ok
);
  assign wr_ok = !status_q[BSY_BIT] && !status_q[DRQ_BIT];

  for (genvar i = 0; i < NUM_TF; i++) begin : g_tf
    always_ff @(posedge clk) begin
      if (rst)                        tf_q[i] <= '0;
      else if (hit.tf_wr[i] && wr_ok) tf_q[i] <= wbyte;
    end

    p_tf_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (hit.tf_wr[i] && !wr_ok) |=> $stable(tf_q[i]))
      else $error("task-file write landed while blocked");
    p_tf_store_r2: assert property (@(posedge clk) disable iff (rst)
      (hit.tf_wr[i] && wr_ok) |=> (tf_q[i] == $past(wbyte)))
      else $error("permitted task-file write lost");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      devctl_q <= '0;
      status_q <= STATUS_RST;
      error_q  <= ERROR_RST;
      cmd_stb  <= 1'b0;
      cmd_code <= '0;
    end else begin
      if (hit.ctl_wr)    devctl_q <= wbyte;
      if (eng_status_we) status_q <= eng_status;
      if (eng_error_we)  error_q  <= eng_error;
      cmd_stb <= hit.cmd_wr && wr_ok;
      if (hit.cmd_wr && wr_ok) cmd_code <= wbyte;
    end
  end

  p_cmd_gate_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> $past(wr_ok))
    else $error("command issued while writes blocked");
  p_status_owner_r5: assert property (@(posedge clk) disable iff (rst)
    !eng_status_we |=> $stable(status_q))
    else $error("status changed without engine load");
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (set_req) irq <= 1'b1;
    else if (clr_req) irq <= 1'b0;
  end

  p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
    set_req |=> irq)
    else $error("interrupt request not latched");
  p_irq_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_req) |=> !irq)
    else $error("interrupt not cleared");
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !set_req) |=> $stable(irq))
    else $error("interrupt changed without cause");
endmodule

// File: rtl/ata_tf_hostport.sv
module ata_tf_hostport
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  hit_t                         hit,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic [NUM_TF-1:0][REG_W-1:0] tf_q,
  input  logic [REG_W-1:0]             status_q,
  input  logic [REG_W-1:0]             error_q,
  input  logic [DATA_W-1:0]            buf_rdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         buf_rd_stb,
  output logic                         buf_wr_stb,
  output logic [DATA_W-1:0]            buf_wdata
);
  localparam int PAD_W = DATA_W - REG_W;

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_DATA)
      rd_next = buf_rdata;
    else if (bus_addr == A_FEAT)
      rd_next = {{PAD_W{1'b0}}, error_q};
    else if (bus_addr == A_CMD || bus_addr == A_ALT)
      rd_next = {{PAD_W{1'b0}}, status_q};
    else
      for (int i = 1; i < NUM_TF; i++)
        if (bus_addr == A_FEAT + ADDR_W'(i))
          rd_next = {{PAD_W{1'b0}}, tf_q[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      buf_rd_stb <= 1'b0;
      buf_wr_stb <= 1'b0;
      buf_wdata  <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      buf_rd_stb <= hit.data_rd;
      buf_wr_stb <= hit.data_wr;
      if (hit.data_wr) buf_wdata <= bus_wdata;
    end
  end

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata))
    else $error("read data moved without a read");
  p_bufrd_src_r9: assert property (@(posedge clk) disable iff (rst)
    buf_rd_stb |-> $past(bus_rd && bus_addr == A_DATA))
    else $error("pop strobe without data-port read");
  p_bufwr_src_r9: assert property (@(posedge clk) disable iff (rst)
    buf_wr_stb |-> $past(bus_wdata) == buf_wdata)
    else $error("pushed word differs from bus word");
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              buf_rd_stb,
  output logic              buf_wr_stb,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              cmd_stb,
  output logic [REG_W-1:0]  cmd_code,
  input  logic              eng_status_we,
  input  logic [REG_W-1:0]  eng_status,
  input  logic              eng_error_we,
  input  logic [REG_W-1:0]  eng_error,
  input  logic              eng_irq,
  output logic [REG_W-1:0]  tf_feature,
  output logic [REG_W-1:0]  tf_count,
  output logic [REG_W-1:0]  tf_lba0,
  output logic [REG_W-1:0]  tf_lba1,
  output logic [REG_W-1:0]  tf_lba2,
  output logic [REG_W-1:0]  tf_device,
  output logic [REG_W-1:0]  tf_devctl,
  output logic              dev_irq
);
  hit_t                         hit;
  logic [NUM_TF-1:0][REG_W-1:0] tf_q;
  logic [REG_W-1:0]             status_q;
  logic [REG_W-1:0]             error_q;
  logic                         wr_ok;

  ata_tf_decode u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .hit     (hit)
  );

  ata_tf_regfile #(.REG_W(REG_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .hit          (hit),
    .wbyte        (bus_wdata[REG_W-1:0]),
    .eng_status_we(eng_status_we),
    .eng_status   (eng_status),
    .eng_error_we (eng_error_we),
    .eng_error    (eng_error),
    .tf_q         (tf_q),
    .devctl_q     (tf_devctl),
    .status_q     (status_q),
    .error_q      (error_q),
    .cmd_stb      (cmd_stb),
    .cmd_code     (cmd_code),
    .wr_ok        (wr_ok)
  );

  ata_tf_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_req(eng_irq),
    .clr_req(hit.stat_rd || (hit.cmd_wr && wr_ok)),
    .irq    (dev_irq)
  );

  ata_tf_hostport #(.DATA_W(DATA_W), .REG_W(REG_W)) u_host (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tf_q      (tf_q),
    .status_q  (status_q),
    .error_q   (error_q),
    .buf_rdata (buf_rdata),
    .bus_rdata (bus_rdata),
    .buf_rd_stb(buf_rd_stb),
    .buf_wr_stb(buf_wr_stb),
    .buf_wdata (buf_wdata)
  );

  assign tf_feature = tf_q[TF_FEAT];
  assign tf_count   = tf_q[TF_COUNT];
  assign tf_lba0    = tf_q[TF_LBA0];
  assign tf_lba1    = tf_q[TF_LBA1];
  assign tf_lba2    = tf_q[TF_LBA2];
  assign tf_device  = tf_q[TF_DEV];
endmodule

// File: tb/ata_taskfile_regs_test.sv
module ata_taskfile_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, buf_rdata = '0;
  logic [15:0] bus_rdata, buf_wdata;
  logic        buf_rd_stb, buf_wr_stb, cmd_stb, dev_irq;
  logic [7:0]  cmd_code;
  logic        eng_status_we = 1'b0, eng_error_we = 1'b0, eng_irq = 1'b0;
  logic [7:0]  eng_status = '0, eng_error = '0;
  logic [7:0]  tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device, tf_devctl;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ata_taskfile_regs uut (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_status(logic [7:0] v);
    @(negedge clk); eng_status = v; eng_status_we = 1'b1;
    @(negedge clk); eng_status_we = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); eng_irq = 1'b1;
    @(negedge clk); eng_irq = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", 16'(dev_irq), 16'h0);
    chk("R1 count", 16'(tf_count), 16'h0);
    chk("R1 devctl", 16'(tf_devctl), 16'h0);
    chk("R1 cmd_stb", 16'(cmd_stb), 16'h0);
    bus_read(4'd14, d); chk("R1 status", d, 16'h0050);
    bus_read(4'd1, d);  chk("R1 error", d, 16'h0001);
  endtask

  task automatic t_tf_write();
    logic [15:0] d;
    for (int i = 1; i <= 6; i++) bus_write(4'(i), 16'hAB00 | 16'(8'h10 + i));
    chk("R2 feature", 16'(tf_feature), 16'h11);
    chk("R2 count", 16'(tf_count), 16'h12);
    chk("R2 lba0", 16'(tf_lba0), 16'h13);
    chk("R2 lba1", 16'(tf_lba1), 16'h14);
    chk("R2 lba2", 16'(tf_lba2), 16'h15);
    chk("R2 device", 16'(tf_device), 16'h16);
    bus_read(4'd5, d); chk("R2 readback lba2", d, 16'h0015);
    bus_read(4'd1, d); chk("R6 feature addr reads error", d, 16'h0001);
  endtask

  task automatic t_gate();
    set_status(8'hD0);
    bus_write(4'd2, 16'h0077);
    chk("R3 count kept while BSY", 16'(tf_count), 16'h12);
    bus_write(4'd7, 16'h00EC);
    chk("R3 no cmd while BSY", 16'(cmd_stb), 16'h0);
    set_status(8'h58);
    bus_write(4'd6, 16'h00A0);
    chk("R3 device kept while DRQ", 16'(tf_device), 16'h16);
    set_status(8'h50);
  endtask

  task automatic t_cmd();
    pulse_irq();
    chk("R8 irq set", 16'(dev_irq), 16'h1);
    repeat (3) @(negedge clk);
    chk("R8 irq held", 16'(dev_irq), 16'h1);
    bus_write(4'd7, 16'h01EC);
    chk("R4 cmd_stb", 16'(cmd_stb), 16'h1);
    chk("R4 cmd_code", 16'(cmd_code), 16'h00EC);
    chk("R4 irq cleared", 16'(dev_irq), 16'h0);
    @(negedge clk);
    chk("R4 single pulse", 16'(cmd_stb), 16'h0);
  endtask

  task automatic t_status_read();
    logic [15:0] d;
    set_status(8'h51);
    pulse_irq();
    bus_read(4'd14, d);
    chk("R7 alt status value", d, 16'h0051);
    chk("R7 alt keeps irq", 16'(dev_irq), 16'h1);
    bus_read(4'd7, d);
    chk("R7 status value", d, 16'h0051);
    chk("R7 status read clears irq", 16'(dev_irq), 16'h0);
    @(negedge clk); eng_irq = 1'b1; bus_addr = 4'd7; bus_rd = 1'b1;
    @(negedge clk); eng_irq = 1'b0; bus_rd = 1'b0;
    chk("R8 set beats clear", 16'(dev_irq), 16'h1);
    bus_read(4'd7, d);
    set_status(8'h50);
  endtask

  task automatic t_devctl();
    logic [15:0] d;
    set_status(8'h80);
    bus_write(4'd14, 16'h0206);
    chk("R5 devctl while busy", 16'(tf_devctl), 16'h06);
    bus_read(4'd14, d);
    chk("R5 status untouched", d, 16'h0080);
    set_status(8'h50);
  endtask

  task automatic t_data();
    logic [15:0] d;
    set_status(8'h88);
    buf_rdata = 16'h1234;
    @(negedge clk); bus_addr = 4'd0; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R9 data read word", bus_rdata, 16'h1234);
    chk("R9 pop strobe", 16'(buf_rd_stb), 16'h1);
    @(negedge clk);
    chk("R9 pop one cycle", 16'(buf_rd_stb), 16'h0);
    bus_write(4'd0, 16'hBEEF);
    chk("R9 push strobe", 16'(buf_wr_stb), 16'h1);
    chk("R9 push word", buf_wdata, 16'hBEEF);
    @(negedge clk);
    chk("R9 push one cycle", 16'(buf_wr_stb), 16'h0);
    set_status(8'h50);
    bus_read(4'd9, d);
    chk("R10 unmapped reads zero", d, 16'h0000);
    bus_read(4'd3, d);
    repeat (3) @(negedge clk);
    chk("R10 read data holds", bus_rdata, 16'h0013);
  endtask

  task automatic t_error();
    logic [15:0] d;
    @(negedge clk); eng_error = 8'h04; eng_error_we = 1'b1;
    @(negedge clk); eng_error_we = 1'b0;
    bus_read(4'd1, d);
    chk("R11 error load", d, 16'h0004);
    set_status(8'h41);
    bus_read(4'd14, d);
    chk("R11 status load", d, 16'h0041);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tf_write();
    t_gate();
    t_cmd();
    t_status_read();
    t_devctl();
    t_data();
    t_error();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule